// File: doc/BRIEF.md
# Dual-Timer Carrier Modulator

This block merges two timer compare waveforms onto a single shared output pin. One waveform is a slow modulating signal, typically a PWM output from a wide timer. The other is a fast carrier, typically a toggle output from a narrow timer. Each channel has its own compare-output-mode field. When a field is nonzero, that channel's waveform takes the pin away from the port data bit.

When both channels are enabled, modulation switches on by itself, with no separate enable. The port data bit then stops being pin data and becomes the combine select: 0 gives AND and 1 gives OR. Each waveform passes through a register before it reaches the combining logic. The pin output-enable comes from the direction bit alone. Both the port data bit and the direction bit are written through a one-bit register interface.

A consequence of combining in this way is that the PWM resolution seen at the pin falls by the carrier period in clocks. For example, with a two-clock carrier, PWM high times that differ by one clock can give the same pin waveform.

Top module: `carrier_modulator`

## Requirements
- R1: After reset, pin_o is 0, pin_oe_o is 0, and both the port data bit and the direction bit are 0.
- R2: A write takes effect in the cycle after the rising clock edge at which reg_we_i is 1. With reg_sel_i = 0 the write goes to the port data bit, and with reg_sel_i = 1 it goes to the direction bit. When reg_we_i is 0, neither bit changes, whatever reg_sel_i and reg_wdata_i are.
- R3: When both mode fields are zero, pin_o equals the port data bit.
- R4: When only mod_mode_i is nonzero, pin_o equals mod_wave_i as sampled at the previous rising edge (a one-register delay).
- R5: When only car_mode_i is nonzero, pin_o equals car_wave_i as sampled at the previous rising edge.
- R6: When both mode fields are nonzero and the port data bit is 0, pin_o is the AND of the two registered waveforms.
- R7: When both mode fields are nonzero and the port data bit is 1, pin_o is the OR of the two registered waveforms.
- R8: pin_oe_o equals the direction bit for every combination of mode fields.
- R9: Each of the nonzero mode values 1, 2 and 3 enables its channel in the same way.
- R10: Take a carrier that is 1 on even cycles and 0 on odd cycles, in AND mode, and an 8-cycle PWM that starts aligned with a carrier high. A high time of 4 and a high time of 3 then give the same pin sequence: 1,0,1,0,0,0,0,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_wave_i | input | 1 | Raw modulating waveform |
| car_wave_i | input | 1 | Raw carrier waveform |
| mod_mode_i | input | MODE_W | Mode field of the modulating channel; nonzero enables the channel |
| car_mode_i | input | MODE_W | Mode field of the carrier channel; nonzero enables the channel |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = port data, 1 = direction |
| reg_wdata_i | input | 1 | Write data |
| pin_o | output | 1 | Pin drive value |
| pin_oe_o | output | 1 | Pin output-enable |

## Verification
The bench goes through every pair of mode values with both settings of the port data bit and all four waveform values, and compares the pin against a reference model.

- A design that took only one mode bit as the enable would pass the port data bit through for mode value 2.
- A design with the select polarity reversed would output OR where AND is expected.
- A design that dropped the waveform register would show the pin changing one cycle early in the single-channel cases.

Further directed tests cover the following:
- Writes with the strobe low, which must leave the pin unchanged.
- The direction bit while modulation is active, which must still drive the output-enable.
- The pair of PWM periods whose high times differ by one clock, which must give the same pin sequence at the lower resolution.

// File: rtl/cm_pkg.sv
package cm_pkg;

   typedef enum logic [1:0] {
      SRC_PORT = 2'd0,
      SRC_MOD  = 2'd1,
      SRC_CAR  = 2'd2,
      SRC_MIX  = 2'd3
   } cm_src_e;

   typedef enum logic {
      REG_DATA = 1'b0,
      REG_DIR  = 1'b1
   } cm_reg_e;

   function automatic cm_src_e pick_src(input logic mod_en, input logic car_en);
      case ({mod_en, car_en})
         2'b10:   return SRC_MOD;
         2'b01:   return SRC_CAR;
         2'b11:   return SRC_MIX;
         default: return SRC_PORT;
      endcase
   endfunction

endpackage

// File: rtl/cm_wave_reg.sv
module cm_wave_reg #(
   parameter int STAGES = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] sh_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sh_q <= '0;
            else         sh_q <= d_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sh_q <= '0;
            else         sh_q <= {sh_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/cm_port_regs.sv
module cm_port_regs
   import cm_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic we_i,
   input  logic sel_i,
   input  logic wdata_i,
   output logic data_o,
   output logic dir_o
);

   logic data_q, dir_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         data_q <= 1'b0;
         dir_q  <= 1'b0;
      end else if (we_i) begin
         if (cm_reg_e'(sel_i) == REG_DIR) dir_q  <= wdata_i;
         else                             data_q <= wdata_i;
      end
   end

   assign data_o = data_q;
   assign dir_o  = dir_q;

   // R2: a strobed direction write is visible on the next cycle
   a_r2_dir_write : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && sel_i == REG_DIR) |=> (dir_o == $past(wdata_i)));

   // R2: with the strobe low, neither bit moves
   a_r2_no_write : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> ($stable(data_o) && $stable(dir_o)));

endmodule

// File: rtl/cm_combiner.sv
module cm_combiner
   import cm_pkg::*;
(
   input  logic mod_en_i,
   input  logic car_en_i,
   input  logic mod_q_i,
   input  logic car_q_i,
   input  logic port_data_i,
   output logic pin_o
);

   cm_src_e src;
   logic    mixed;

   assign src = pick_src(mod_en_i, car_en_i);

   // In mixing mode the port data bit is the combine select: 1 = OR, 0 = AND
   always_comb begin
      if (port_data_i) mixed = mod_q_i | car_q_i;
      else             mixed = mod_q_i & car_q_i;
   end

   always_comb begin
      unique case (src)
         SRC_MOD: pin_o = mod_q_i;
         SRC_CAR: pin_o = car_q_i;
         SRC_MIX: pin_o = mixed;
         default: pin_o = port_data_i;
      endcase
   end

endmodule

// File: rtl/carrier_modulator.sv
module carrier_modulator
   import cm_pkg::*;
#(
   parameter int MODE_W      = 2,
   parameter int WAVE_STAGES = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mod_wave_i,
   input  logic              car_wave_i,
   input  logic [MODE_W-1:0] mod_mode_i,
   input  logic [MODE_W-1:0] car_mode_i,
   input  logic              reg_we_i,
   input  logic              reg_sel_i,
   input  logic              reg_wdata_i,
   output logic              pin_o,
   output logic              pin_oe_o
);

   localparam int CNT_W = $clog2(WAVE_STAGES + 1) + 1;

   generate
      if (MODE_W < 1) begin : g_bad_mode_w
         initial $fatal(1, "carrier_modulator: MODE_W must be at least 1");
      end
      if (WAVE_STAGES < 1 || WAVE_STAGES > 4) begin : g_bad_stages
         initial $fatal(1, "carrier_modulator: WAVE_STAGES must lie in 1..4");
      end
   endgenerate

   logic mod_en, car_en;
   logic mod_q, car_q;
   logic port_data, port_dir;

   assign mod_en = |mod_mode_i;
   assign car_en = |car_mode_i;

   cm_wave_reg #(.STAGES(WAVE_STAGES)) u_mod_reg (
      .clk_i (clk_i), .rst_ni(rst_ni), .d_i(mod_wave_i), .q_o(mod_q)
   );

   cm_wave_reg #(.STAGES(WAVE_STAGES)) u_car_reg (
      .clk_i (clk_i), .rst_ni(rst_ni), .d_i(car_wave_i), .q_o(car_q)
   );

   cm_port_regs u_port (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (reg_we_i),
      .sel_i  (reg_sel_i),
      .wdata_i(reg_wdata_i),
      .data_o (port_data),
      .dir_o  (port_dir)
   );

   cm_combiner u_comb (
      .mod_en_i   (mod_en),
      .car_en_i   (car_en),
      .mod_q_i    (mod_q),
      .car_q_i    (car_q),
      .port_data_i(port_data),
      .pin_o      (pin_o)
   );

   assign pin_oe_o = port_dir;

   // Cycles since reset, saturating; used only to gate the delayed-wave checks
   logic [CNT_W-1:0] settle_cnt;
   logic             settled;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  settle_cnt <= '0;
      else if (!settled)            settle_cnt <= settle_cnt + 1'b1;
   end
   assign settled = (settle_cnt == CNT_W'(WAVE_STAGES));

   // R3: neither channel enabled -> pin shows the port data bit
   a_r3_port_pass : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mod_en && !car_en) |-> (pin_o == port_data));

   // R4: only the modulating channel -> its delayed waveform
   a_r4_mod_only : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settled && mod_en && !car_en) |-> (pin_o == $past(mod_wave_i, WAVE_STAGES)));

   // R5: only the carrier channel -> its delayed waveform
   a_r5_car_only : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settled && !mod_en && car_en) |-> (pin_o == $past(car_wave_i, WAVE_STAGES)));

   // R6: both channels, select low -> AND
   a_r6_and_mix : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settled && mod_en && car_en && !port_data) |->
      (pin_o == ($past(mod_wave_i, WAVE_STAGES) & $past(car_wave_i, WAVE_STAGES))));

   // R7: both channels, select high -> OR
   a_r7_or_mix : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settled && mod_en && car_en && port_data) |->
      (pin_o == ($past(mod_wave_i, WAVE_STAGES) | $past(car_wave_i, WAVE_STAGES))));

   // R8: output-enable follows a direction write, whatever the modes
   a_r8_oe_dir : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_sel_i) |=> (pin_oe_o == $past(reg_wdata_i)));

endmodule

// File: tb/carrier_modulator_bench.sv
module carrier_modulator_bench;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mod_w = 1'b0, car_w = 1'b0;
   logic [1:0] mod_m = '0, car_m = '0;
   logic       we = 1'b0, sel = 1'b0, wd = 1'b0;
   logic       pin, oe;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   carrier_modulator u_carrier_modulator (
      .clk_i(clk), .rst_ni(rst_n),
      .mod_wave_i(mod_w), .car_wave_i(car_w),
      .mod_mode_i(mod_m), .car_mode_i(car_m),
      .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wd),
      .pin_o(pin), .pin_oe_o(oe)
   );

   // Vector: {mod_mode[1:0], car_mode[1:0], port_data, mod_wave, car_wave, expected_pin}
   localparam logic [7:0] VEC [12] = '{
      {2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1},  // R3
      {2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0},  // R3
      {2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1},  // R4, R9
      {2'd3, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0},  // R4, R9
      {2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1},  // R5
      {2'd0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0},  // R5, R9
      {2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0},  // R6
      {2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1},  // R6
      {2'd3, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0},  // R6
      {2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1},  // R7
      {2'd2, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0},  // R7
      {2'd1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1}   // R7
   };

   function automatic logic ref_pin(input logic [1:0] mm, input logic [1:0] cm,
                                    input logic pd, input logic mw, input logic cw);
      if (mm != 0 && cm != 0) return pd ? (mw | cw) : (mw & cw);
      if (mm != 0)            return mw;
      if (cm != 0)            return cw;
      return pd;
   endfunction

   function automatic string req_of(input logic [1:0] mm, input logic [1:0] cm, input logic pd);
      if (mm != 0 && cm != 0) return pd ? "R7" : "R6";
      if (mm != 0)            return "R4";
      if (cm != 0)            return "R5";
      return "R3";
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic write_reg(input logic s, input logic d);
      we = 1'b1; sel = s; wd = d;
      @(posedge clk); #1;
      we = 1'b0;
   endtask

   // Drive modes/waves, clock once, then compare with the reference
   task automatic apply(input logic [1:0] mm, input logic [1:0] cm, input logic mw,
                        input logic cw, input logic pd, input string req, input logic exp);
      mod_m = mm; car_m = cm; mod_w = mw; car_w = cw;
      @(posedge clk); #1;
      check(req, pin, exp);
   endtask

   task automatic pwm_run(input int high, output logic [7:0] seq);
      for (int k = 0; k < 8; k++) begin
         mod_w = (k < high);
         car_w = (k % 2 == 0);
         @(posedge clk); #1;
         seq[k] = pin;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] seq_a, seq_b;
      logic       hold;

      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1 pin", pin, 1'b0);
      check("R1 oe",  oe,  1'b0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 pin after release", pin, 1'b0);

      // R2 and R8: direction write
      write_reg(1'b1, 1'b1);
      check("R8 oe set", oe, 1'b1);
      write_reg(1'b0, 1'b1);
      check("R2 data write", pin, 1'b1);

      // R2: strobe low leaves both bits unchanged
      we = 1'b0; sel = 1'b0; wd = 1'b0;
      @(posedge clk); #1;
      check("R2 no strobe data", pin, 1'b1);
      sel = 1'b1;
      @(posedge clk); #1;
      check("R2 no strobe dir", oe, 1'b1);

      // Table walk
      for (int i = 0; i < 12; i++) begin
         write_reg(1'b0, VEC[i][3]);
         apply(VEC[i][7:6], VEC[i][5:4], VEC[i][2], VEC[i][1], VEC[i][3],
               $sformatf("%s table %0d", req_of(VEC[i][7:6], VEC[i][5:4], VEC[i][3]), i),
               VEC[i][0]);
      end

      // R9 with R3..R7: exhaustive mode pairs against the reference model
      for (int pd = 0; pd < 2; pd++) begin
         write_reg(1'b0, pd[0]);
         for (int mm = 0; mm < 4; mm++)
            for (int cm = 0; cm < 4; cm++)
               for (int w = 0; w < 4; w++)
                  apply(mm[1:0], cm[1:0], w[1], w[0], pd[0],
                        $sformatf("%s R9 sweep", req_of(mm[1:0], cm[1:0], pd[0])),
                        ref_pin(mm[1:0], cm[1:0], pd[0], w[1], w[0]));
      end

      // R4: the one-cycle delay is visible when the wave changes after sampling
      write_reg(1'b0, 1'b0);
      mod_m = 2'd1; car_m = 2'd0; mod_w = 1'b1;
      @(posedge clk); #1;
      mod_w = 1'b0;
      #1;
      check("R4 registered wave holds", pin, 1'b1);
      @(posedge clk); #1;
      check("R4 registered wave follows", pin, 1'b0);

      // R8: direction clear during modulation
      mod_m = 2'd2; car_m = 2'd1;
      write_reg(1'b1, 1'b0);
      check("R8 oe cleared while mixing", oe, 1'b0);
      write_reg(1'b1, 1'b1);
      check("R8 oe set while mixing", oe, 1'b1);

      // R2: a strobe-low write while mixing must not alter the AND/OR select
      write_reg(1'b0, 1'b0);
      we = 1'b0; sel = 1'b0; wd = 1'b1;
      mod_w = 1'b1; car_w = 1'b0;
      @(posedge clk); #1;
      hold = pin;
      check("R2 select untouched", hold, 1'b0);

      // R10: resolution loss with a 2-cycle carrier in AND mode
      mod_w = 1'b0; car_w = 1'b0;
      @(posedge clk); #1;
      pwm_run(4, seq_a);
      pwm_run(3, seq_b);
      check("R10 high time 4 pattern", seq_a == 8'h05, 1'b1);
      check("R10 high time 3 pattern", seq_b == 8'h05, 1'b1);
      check("R10 equal periods", seq_a == seq_b, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule